// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath with Step Sequencer

This block is a small accumulator datapath in which one shared internal bus links the instruction register, the memory address register (MAR), the memory buffer register (MBR), the operand register Y, the result register Z and the accumulator. The ALU is purely combinational. Its output is never placed on the bus. The result is first captured in Z and then moved to the accumulator in a later step. Each register that can drive the bus has its own drive enable, and each register that takes data from the bus has its own load enable. A step sequencer raises these enables one step at a time.

A client starts an instruction by holding `start` high for one cycle while the sequencer is idle, with the instruction on `instr`. The instruction is a 3-bit opcode in bits [8:6] and a memory address in bits [5:0]. The sequencer then runs five steps:
- T1: MAR is loaded from the address field of the IR.
- T2: MBR is loaded from memory.
- T3: MBR is copied into Y over the bus.
- T4: Z is loaded with the ALU result of the accumulator combined with Y.
- T5: Z is copied into the accumulator over the bus, and the program counter increments.

A single DONE cycle with `done` high follows. The memory port is a simple synchronous read port: `mem_rd` and `mem_addr` are presented during T2, and `mem_rdata` is captured at the end of that same cycle.

The states are IDLE, T1, T2, T3, T4, T5 and DONE. The transitions are:
- IDLE to T1 when `start` is high.
- IDLE to IDLE otherwise.
- T1 to T2, T2 to T3, T3 to T4, T4 to T5 and T5 to DONE, each unconditionally.
- DONE to IDLE unconditionally.

Top module: `onebus_core`

## Requirements
- R1: After reset, `acc`, `pc`, `busy`, `done` and `mem_rd` are all zero.
- R2: `start` sampled high in IDLE moves the sequencer through T1 to T5 and then DONE. `done` is high only in the DONE cycle, which is the sixth cycle after the sampling edge. `busy` is high from T1 through DONE, and the sequencer is back in IDLE in the following cycle.
- R3: `mem_rd` is high only in T2, for exactly one cycle, and `mem_addr` then equals the address field `instr[5:0]`.
- R4: Opcodes act on the accumulator A and the memory word M, modulo 2^8, as follows: 0 gives M (load), 1 gives A+M, 2 gives A-M, 3 gives A AND M, and 4 gives A OR M.
- R5: Opcodes 5, 6 and 7 leave the accumulator unchanged, although the full step sequence still runs.
- R6: The accumulator changes value only at the edge that enters DONE.
- R7: `pc` increments by one, wrapping modulo 2^6, once for each completed instruction, at the same edge that updates the accumulator.
- R8: `start` asserted while `busy` is high has no effect: the running instruction completes with its own result, and no new sequence begins.
- R9: In any cycle, at most one register drives the internal bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an instruction (sampled only in IDLE) |
| instr | input | 9 | Opcode [8:6], memory address [5:0] |
| busy | output | 1 | Sequencer is not idle |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 6 | Memory address, taken from MAR |
| mem_rd | output | 1 | Memory read strobe (T2) |
| mem_rdata | input | 8 | Memory read data |
| acc | output | 8 | Accumulator |
| pc | output | 6 | Completed-instruction program counter |

## Verification
The bench sweeps all eight opcodes over operand pairs that include zero, one, the sign boundary and all-ones. This exposes carry and borrow wraparound errors, as well as wrong decoding of the reserved codes, which would show up as a corrupted accumulator. For every instruction it counts cycles to `done` and checks that the memory strobe appears only in T2 with the right address. A sequencer that skipped or doubled a step, or read in the wrong step, would shift or duplicate the pulse. Some runs assert `start` again in mid-sequence with a different instruction: a design that restarted or re-latched the IR would either load the wrong memory word or stay busy after DONE. The `pc` is tracked across many wraps to catch a counter that updates at the wrong step or more than once per instruction.

// File: rtl/onebus_pkg.sv
package onebus_pkg;

    localparam int OPC_W = 3;

    localparam logic [OPC_W-1:0] OP_PASS = 3'd0;
    localparam logic [OPC_W-1:0] OP_ADD  = 3'd1;
    localparam logic [OPC_W-1:0] OP_SUB  = 3'd2;
    localparam logic [OPC_W-1:0] OP_AND  = 3'd3;
    localparam logic [OPC_W-1:0] OP_OR   = 3'd4;

    // bus drivers, one enable bit each
    localparam int N_DRV   = 3;
    localparam int DRV_IRA = 0;
    localparam int DRV_MBR = 1;
    localparam int DRV_Z   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4,
        ST_T5,
        ST_DONE
    } step_t;

    typedef struct packed {
        logic [N_DRV-1:0] drv;
        logic             ld_mar;
        logic             ld_mbr;
        logic             ld_y;
        logic             ld_z;
        logic             ld_ac;
        logic             inc_pc;
        logic             mem_rd;
        logic             done;
        logic             busy;
    } ctl_t;

endpackage

// File: rtl/onebus_seq.sv
module onebus_seq
    import onebus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ld_ir,
    output ctl_t ctl
);

    step_t state_q;
    step_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_T1;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3:   state_d = ST_T4;
            ST_T4:   state_d = ST_T5;
            ST_T5:   state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl   = '0;
        ld_ir = 1'b0;
        unique case (state_q)
            ST_IDLE: ld_ir = start;
            ST_T1: begin
                ctl.drv[DRV_IRA] = 1'b1;
                ctl.ld_mar       = 1'b1;
            end
            ST_T2: begin
                ctl.mem_rd = 1'b1;
                ctl.ld_mbr = 1'b1;
            end
            ST_T3: begin
                ctl.drv[DRV_MBR] = 1'b1;
                ctl.ld_y         = 1'b1;
            end
            ST_T4: ctl.ld_z = 1'b1;
            ST_T5: begin
                ctl.drv[DRV_Z] = 1'b1;
                ctl.ld_ac      = 1'b1;
                ctl.inc_pc     = 1'b1;
            end
            ST_DONE: ctl.done = 1'b1;
            default: ;
        endcase
        ctl.busy = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/onebus_alu.sv
module onebus_alu
    import onebus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OPC_W-1:0]  op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        case (op)
            OP_PASS: y = b;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/onebus_regs.sv
module onebus_regs
    import onebus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_ir,
    input  logic [OPC_W+ADDR_W-1:0] instr,
    input  logic [N_DRV-1:0]        drv,
    input  logic                    ld_mar,
    input  logic                    ld_mbr,
    input  logic                    ld_y,
    input  logic                    ld_z,
    input  logic                    ld_ac,
    input  logic                    inc_pc,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic [DATA_W-1:0]       alu_y,
    output logic [OPC_W-1:0]        opcode,
    output logic [DATA_W-1:0]       ac_q,
    output logic [DATA_W-1:0]       y_q,
    output logic [ADDR_W-1:0]       mar_q,
    output logic [ADDR_W-1:0]       pc_q
);

    localparam int IR_W = OPC_W + ADDR_W;

    logic [IR_W-1:0]   ir_q;
    logic [DATA_W-1:0] mbr_q;
    logic [DATA_W-1:0] z_q;
    logic [DATA_W-1:0] bus;

    logic [N_DRV-1:0][DATA_W-1:0] src;
    logic [N_DRV-1:0][DATA_W-1:0] gated;

    assign src[DRV_IRA] = DATA_W'(ir_q[ADDR_W-1:0]);
    assign src[DRV_MBR] = mbr_q;
    assign src[DRV_Z]   = z_q;

    for (genvar g = 0; g < N_DRV; g++) begin : g_drv
        assign gated[g] = drv[g] ? src[g] : '0;
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < N_DRV; i++) begin
            bus = bus | gated[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q  <= '0;
            mar_q <= '0;
            mbr_q <= '0;
            y_q   <= '0;
            z_q   <= '0;
            ac_q  <= '0;
            pc_q  <= '0;
        end else begin
            if (ld_ir)  ir_q  <= instr;
            if (ld_mar) mar_q <= bus[ADDR_W-1:0];
            if (ld_mbr) mbr_q <= mem_rdata;
            if (ld_y)   y_q   <= bus;
            if (ld_z)   z_q   <= alu_y;
            if (ld_ac)  ac_q  <= bus;
            if (inc_pc) pc_q  <= pc_q + 1'b1;
        end
    end

    assign opcode = ir_q[IR_W-1:ADDR_W];

endmodule

// File: rtl/onebus_core.sv
module onebus_core
    import onebus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [OPC_W+ADDR_W-1:0] instr,
    output logic                    busy,
    output logic                    done,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_rd,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [DATA_W-1:0]       acc,
    output logic [ADDR_W-1:0]       pc
);

    ctl_t              ctl;
    logic              ld_ir;
    logic [N_DRV-1:0]  drv_en;
    logic [OPC_W-1:0]  opcode;
    logic [DATA_W-1:0] y_q;
    logic [DATA_W-1:0] alu_y;

    onebus_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ld_ir (ld_ir),
        .ctl   (ctl)
    );

    assign drv_en = ctl.drv;

    onebus_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_ir     (ld_ir),
        .instr     (instr),
        .drv       (drv_en),
        .ld_mar    (ctl.ld_mar),
        .ld_mbr    (ctl.ld_mbr),
        .ld_y      (ctl.ld_y),
        .ld_z      (ctl.ld_z),
        .ld_ac     (ctl.ld_ac),
        .inc_pc    (ctl.inc_pc),
        .mem_rdata (mem_rdata),
        .alu_y     (alu_y),
        .opcode    (opcode),
        .ac_q      (acc),
        .y_q       (y_q),
        .mar_q     (mem_addr),
        .pc_q      (pc)
    );

    onebus_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op (opcode),
        .a  (acc),
        .b  (y_q),
        .y  (alu_y)
    );

    assign busy   = ctl.busy;
    assign done   = ctl.done;
    assign mem_rd = ctl.mem_rd;

endmodule

// File: rtl/onebus_core_chk.sv
module onebus_core_chk
    import onebus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic [DATA_W-1:0] acc,
    input logic [ADDR_W-1:0] pc,
    input logic [N_DRV-1:0]  drv_en
);

    // R9: a single bus driver at most
    assert_bus_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_en));

    // R2: completion pulse lasts one cycle and falls inside the busy window
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R3: read strobe is a single cycle
    assert_rd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R6: accumulator moves only on entry to DONE
    assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc) |-> done);

    // R7: counter moves only on entry to DONE, by exactly one
    assert_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> done);
    assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pc == ADDR_W'($past(pc) + 1'b1)));

endmodule

bind onebus_core onebus_core_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .mem_rd (mem_rd),
    .acc    (acc),
    .pc     (pc),
    .drv_en (drv_en)
);

// File: tb/onebus_core_test.sv
module onebus_core_test;

    localparam int DW = 8;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [8:0]    instr = '0;
    logic          busy, done, mem_rd;
    logic [AW-1:0] mem_addr, pc;
    logic [DW-1:0] mem_rdata, acc;
    logic [DW-1:0] mem [64];

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [AW-1:0] exp_pc = '0;

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    onebus_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .instr     (instr),
        .busy      (busy),
        .done      (done),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .acc       (acc),
        .pc        (pc)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model(input logic [2:0] op,
                                            input logic [DW-1:0] a,
                                            input logic [DW-1:0] m);
        case (op)
            3'd0: return m;
            3'd1: return a + m;
            3'd2: return a - m;
            3'd3: return a & m;
            3'd4: return a | m;
            default: return a;
        endcase
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [AW-1:0] addr,
                          input logic [DW-1:0] data, input bit poke,
                          input logic [DW-1:0] exp_acc);
        int cyc;
        mem[addr] = data;
        mem[~addr] = ~data;
        @(negedge clk);
        start = 1'b1;
        instr = {op, addr};
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        check(busy == 1'b1, "R2 busy in T1", busy, 1);
        while (!done && cyc < 12) begin
            if (cyc == 2)
                check(mem_rd && mem_addr == addr, "R3 read strobe/address in T2",
                      {mem_rd, mem_addr}, {1'b1, addr});
            else
                check(!mem_rd, "R3 no read outside T2", mem_rd, 0);
            if (poke && cyc == 3) begin
                start = 1'b1;
                instr = {3'd2, ~addr};
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        check(cyc == 6, "R2 done on sixth cycle", cyc, 6);
        exp_pc = exp_pc + 1'b1;
        check(acc == exp_acc, (op > 3'd4) ? "R5 reserved opcode result" :
              "R4 opcode result", acc, exp_acc);
        check(pc == exp_pc, "R7 pc step", pc, exp_pc);
        @(negedge clk);
        check(!done && !busy, poke ? "R8 no restart after mid-run start" :
              "R2 idle after DONE", {done, busy}, 0);
        check(acc == exp_acc, "R6 acc held after DONE", acc, exp_acc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] vals [8];
        vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h7F; vals[3] = 8'h80;
        vals[4] = 8'hFE; vals[5] = 8'hFF; vals[6] = 8'h55; vals[7] = 8'hA3;
        for (int i = 0; i < 64; i++) mem[i] = DW'(i * 37 + 11);

        repeat (3) @(negedge clk);
        check(acc == 0 && pc == 0 && !busy && !done && !mem_rd, "R1 reset state",
              {acc, pc, busy, done, mem_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(acc == 0 && pc == 0 && !busy && !done && !mem_rd, "R1 after reset release",
              {acc, pc, busy, done, mem_rd}, 0);

        for (int op = 0; op < 8; op++) begin
            for (int ia = 0; ia < 8; ia++) begin
                for (int ib = 0; ib < 8; ib++) begin
                    logic [AW-1:0] ad;
                    ad = AW'(ia * 8 + ib + op);
                    // load A through opcode 0, then apply op with M
                    run_op(3'd0, ~ad, vals[ia], 1'b0, vals[ia]);
                    run_op(3'(op), ad, vals[ib], (ib == 3),
                           model(3'(op), vals[ia], vals[ib]));
                end
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule